// File: doc/BRIEF.md
# One-Bit DRAM Record and Playback Sequencer

This block is the control sequencer of a one-bit recorder built around a single-bit-wide dynamic memory. After reset it fills the whole memory once. At each location it stores one sample of a serial input bit. When every location has been written, it switches to playback and streams the stored bits to its output in an endless loop until the next reset.

The sequencer does not drive memory pins itself. It talks to two companion blocks: a refresh engine and an access controller. Each one is started by a single-cycle start pulse and reports completion with a done pulse. Every step of either mode follows the same order:

1. Request a refresh burst and wait for it to finish.
2. Issue one write or read request and wait for it to finish.
3. Advance the address.

The address is held as a row field and a column field. The row field counts first, and a carry out of the column field ends recording. In record mode the captured sample is also echoed to the output. In playback the output follows the data read back.

Top module: `bitrec_seq`

## Requirements
- R1: While reset is held and just after release, `play_mode`, `bit_out`, `mem_row` and `mem_col` are 0.
- R2: After reset, one refresh burst is issued as initialization before the first step, so exactly two refresh requests precede the first access request.
- R3: Exactly one refresh request is issued, and its `refresh_done` is seen, between any two consecutive access requests.
- R4: The linear address {`mem_col`,`mem_row`} (column in the upper bits) starts at 0 and increases by one per step. The row field counts first, and it wraps from all ones to 0 while carrying into the column field.
- R5: The first 2^(ROW_W+COL_W) accesses are writes (`mem_write`=1) with `play_mode`=0. `play_mode` rises after the write to the all-ones address. All later accesses are reads (`mem_write`=0), and `play_mode` stays 1 until reset.
- R6: `mem_wdata` is `sample_in` as captured on the clock edge where `refresh_done` is seen. It is valid at the `mem_start` pulse and holds, together with `mem_row` and `mem_col`, until `mem_done`.
- R7: During record, `bit_out` equals the captured sample of the current write from the `mem_start` cycle onward.
- R8: During playback, `bit_out` takes the value of `mem_rdata` present with `mem_done`, from the following cycle, and holds it until the next read completes.
- R9: During playback, the address wraps from all ones back to 0 and the read loop continues with no limit.
- R10: `mem_start` and `refresh_start` are single-cycle pulses. No new request of either kind is issued while an access is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_in | input | 1 | Serial bit to record |
| refresh_start | output | 1 | One-cycle request for a refresh burst |
| refresh_done | input | 1 | Pulse: refresh burst finished |
| mem_start | output | 1 | One-cycle access request |
| mem_write | output | 1 | 1 = write, 0 = read, valid with mem_start |
| mem_row | output | ROW_W | Row field (low address half) |
| mem_col | output | COL_W | Column field (high address half) |
| mem_wdata | output | 1 | Bit to write |
| mem_rdata | input | 1 | Read data, valid with mem_done |
| mem_done | input | 1 | Pulse: access finished |
| play_mode | output | 1 | 0 = record, 1 = playback |
| bit_out | output | 1 | Echoed sample or played-back bit |

## Verification
The bench builds the sequencer with ROW_W=2 and COL_W=2, which gives a 16-location memory. At that size the row carry, the column carry, the switch to playback and several playback wraps all happen within a few hundred cycles. Every location can then be checked against an address-derived data pattern. A second reset in the middle of playback, with a different pattern, confirms that recording restarts from address 0 and overwrites the memory.

// File: rtl/bitrec_seq.sv
module bitrec_seq #(
  parameter int ROW_W = 10,
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_in,
  output logic             refresh_start,
  input  logic             refresh_done,
  output logic             mem_start,
  output logic             mem_write,
  output logic [ROW_W-1:0] mem_row,
  output logic [COL_W-1:0] mem_col,
  output logic             mem_wdata,
  input  logic             mem_rdata,
  input  logic             mem_done,
  output logic             play_mode,
  output logic             bit_out
);

  localparam logic [ROW_W-1:0] ROW_LAST = {ROW_W{1'b1}};
  localparam logic [COL_W-1:0] COL_LAST = {COL_W{1'b1}};

  typedef enum logic [2:0] {
    S_INIT_REQ, S_INIT_WAIT, S_REF_REQ, S_REF_WAIT, S_ACC_REQ, S_ACC_WAIT, S_STEP
  } st_t;

  st_t              st;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic             play_q, wdata_q, out_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_INIT_REQ;
      row_q   <= '0;
      col_q   <= '0;
      play_q  <= 1'b0;
      wdata_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      case (st)
        S_INIT_REQ:  st <= S_INIT_WAIT;
        S_INIT_WAIT: if (refresh_done) st <= S_REF_REQ;
        S_REF_REQ:   st <= S_REF_WAIT;
        S_REF_WAIT:
          if (refresh_done) begin
            st <= S_ACC_REQ;
            if (!play_q) begin
              wdata_q <= sample_in;
              out_q   <= sample_in;
            end
          end
        S_ACC_REQ:   st <= S_ACC_WAIT;
        S_ACC_WAIT:
          if (mem_done) begin
            st <= S_STEP;
            if (play_q) out_q <= mem_rdata;
          end
        S_STEP: begin
          st    <= S_REF_REQ;
          row_q <= row_q + 1'b1;
          if (row_q == ROW_LAST) begin
            col_q <= col_q + 1'b1;
            if (col_q == COL_LAST) play_q <= 1'b1;
          end
        end
        default: st <= S_INIT_REQ;
      endcase
    end
  end

  assign refresh_start = (st == S_INIT_REQ) || (st == S_REF_REQ);
  assign mem_start     = (st == S_ACC_REQ);
  assign mem_write     = !play_q;
  assign mem_row       = row_q;
  assign mem_col       = col_q;
  assign mem_wdata     = wdata_q;
  assign play_mode     = play_q;
  assign bit_out       = out_q;

  assert_row_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_STEP && row_q == ROW_LAST) |=> (row_q == '0));

  assert_play_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    play_q |=> play_q);

  assert_hold_during_access_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ACC_WAIT) |-> ($stable(mem_row) && $stable(mem_col) && $stable(mem_wdata)));

  assert_no_req_while_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_start || (st == S_ACC_WAIT && !mem_done)) |=> (!mem_start && !refresh_start));

endmodule

// File: tb/test_bitrec_seq.sv
module test_bitrec_seq;
  localparam int CLK_PERIOD = 10;
  localparam int RW = 2;
  localparam int CW = 2;
  localparam int NLOC = 1 << (RW + CW);

  logic clk = 0, rst_n = 0;
  logic sample_in, refresh_start, refresh_done, mem_start, mem_write;
  logic [RW-1:0] mem_row;
  logic [CW-1:0] mem_col;
  logic mem_wdata, mem_rdata, mem_done, play_mode, bit_out;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitrec_seq #(.ROW_W(RW), .COL_W(CW)) i_bitrec_seq (
    .clk(clk), .rst_n(rst_n), .sample_in(sample_in),
    .refresh_start(refresh_start), .refresh_done(refresh_done),
    .mem_start(mem_start), .mem_write(mem_write),
    .mem_row(mem_row), .mem_col(mem_col), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_done(mem_done),
    .play_mode(play_mode), .bit_out(bit_out));

  int checks = 0, fails = 0;
  int phase = 0;

  function automatic logic pat(input int a, input int ph);
    return logic'((((a * 7) + ph * 3) % 5) >= 2);
  endfunction

  assign sample_in = pat(int'({mem_col, mem_row}), phase);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // companion models
  int ref_cnt = 0, mem_cnt = 0;
  logic mem_arr [NLOC];
  int   m_addr;
  logic m_we, m_wd;
  initial begin
    refresh_done = 0; mem_done = 0; mem_rdata = 0;
    for (int i = 0; i < NLOC; i++) mem_arr[i] = 0;
  end

  always @(posedge clk) begin
    refresh_done <= 1'b0;
    mem_done     <= 1'b0;
    if (!rst_n) begin
      ref_cnt <= 0;
      mem_cnt <= 0;
    end else begin
      if (ref_cnt != 0) begin
        ref_cnt <= ref_cnt - 1;
        if (ref_cnt == 1) refresh_done <= 1'b1;
      end else if (refresh_start) ref_cnt <= 2;
      if (mem_cnt != 0) begin
        mem_cnt <= mem_cnt - 1;
        if (mem_cnt == 1) begin
          mem_done <= 1'b1;
          if (m_we) mem_arr[m_addr] <= m_wd;
          else mem_rdata <= mem_arr[m_addr];
        end
      end else if (mem_start) begin
        mem_cnt <= 3;
        m_addr  <= int'({mem_col, mem_row});
        m_we    <= mem_write;
        m_wd    <= mem_wdata;
      end
    end
  end

  // observer
  int   step = 0, ref_since = 0, last_addr = 0;
  bit   waiting = 0, pend = 0, prev_start = 0, last_we = 0;
  int   hold_addr = 0;
  logic hold_wd = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      step = 0; ref_since = 0; waiting = 0; pend = 0; prev_start = 0;
    end else begin
      int a;
      a = int'({mem_col, mem_row});
      if (pend) begin
        chk(bit_out == pat(last_addr, phase), "R8 playback bit", bit_out, pat(last_addr, phase));
        pend = 0;
      end
      if (prev_start) chk(!mem_start && !refresh_start, "R10 single pulse / no new request", mem_start, 0);
      if (waiting && !mem_done) begin
        chk(a == hold_addr && mem_wdata == hold_wd, "R6 hold during access", a, hold_addr);
        chk(!refresh_start, "R10 no refresh while busy", refresh_start, 0);
      end
      if (refresh_start) ref_since++;
      if (mem_start) begin
        chk(ref_since == ((step == 0) ? 2 : 1), (step == 0) ? "R2 init refresh" : "R3 one refresh per step",
            ref_since, (step == 0) ? 2 : 1);
        ref_since = 0;
        chk(a == step % NLOC, (step < NLOC) ? "R4 address order" : "R9 playback wrap", a, step % NLOC);
        chk(mem_write == (step < NLOC), "R5 write vs read", mem_write, step < NLOC);
        chk(play_mode == (step >= NLOC), "R5 mode", play_mode, step >= NLOC);
        if (mem_write) begin
          chk(mem_wdata == pat(a, phase), "R6 write data", mem_wdata, pat(a, phase));
          chk(bit_out == pat(a, phase), "R7 echo", bit_out, pat(a, phase));
        end
        last_addr = a; last_we = mem_write;
        hold_addr = a; hold_wd = mem_wdata;
        step++;
        waiting = 1;
      end else if (mem_done && waiting) begin
        waiting = 0;
        if (!last_we) pend = 1;
      end
      prev_start = mem_start;
    end
  end

  task automatic check_reset_state();
    chk(play_mode == 0, "R1 play_mode", play_mode, 0);
    chk(bit_out == 0, "R1 bit_out", bit_out, 0);
    chk(mem_row == 0 && mem_col == 0, "R1 address", int'({mem_col, mem_row}), 0);
  endtask

  initial begin
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) check_reset_state();
    rst_n = 1;
    @(negedge clk) check_reset_state();
    while (step < NLOC + 40) @(negedge clk);
    @(negedge clk) rst_n = 0;
    phase = 1;
    repeat (2) @(negedge clk);
    check_reset_state();
    rst_n = 1;
    while (step < NLOC + 20) @(negedge clk);
    repeat (20) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule